// File: doc/BRIEF.md
# Constant-Load Register Write Selector

This block sits at the write side of a register file and decides what 64-bit value reaches a destination register. It decodes a 32-bit constant-load instruction word and chooses one of four sources. The first is the crossbar result, passed through unchanged. The second is a full load of a 16-bit immediate, widened with either a sign fill or a zero fill. The third is a partial load, which shifts the old register contents left by 16 bits and places the immediate in the vacated low bits. The fourth clears everything above the low 16 bits of the crossbar result.

A partial load needs the current value of the destination register. The surrounding pipeline must therefore read that register before it issues the write and present the value on `regOld`. The opcode field is compared against a programmable constant-load opcode. The write data, destination index and write enable all leave the block through one register stage.

Top module: `cload_wsel`

## Requirements
- R1: While `rstN` is low, and at the first sample after it goes low, `wrEn` is 0, `wrData` is all zeros and `wrIdx` is 0.
- R2: The instruction word is laid out as opcode in bits 31..24, partial flag in bit 23, sign flag in bit 22, immediate in bits 21..6 and register index in bits 5..0. `wrIdx` equals bits 5..0 of the accepted word in every mode.
- R3: With `modeSel` = 2'b01, a matching opcode, partial flag 0 and sign flag 0, `wrData` is the immediate with bits 63..16 cleared.
- R4: With `modeSel` = 2'b01, a matching opcode, partial flag 0 and sign flag 1, `wrData` is the immediate with bits 63..16 set.
- R5: With `modeSel` = 2'b01, a matching opcode and partial flag 1, `wrData[63:16]` equals `regOld[47:0]` and `wrData[15:0]` equals the immediate.
- R6: With `modeSel` = 2'b00 or 2'b11, `wrData` equals `xbarResult` whatever the instruction fields hold.
- R7: With `modeSel` = 2'b10, `wrData[15:0]` equals `xbarResult[15:0]` and bits 63..16 are cleared.
- R8: With `modeSel` = 2'b01 and an opcode different from `loadOpcode`, `wrData` equals `xbarResult`.
- R9: Each cycle with `instValid` high yields `wrEn` high in the following cycle together with its data and index. A cycle without `instValid` yields `wrEn` low in the following cycle, and `wrData` and `wrIdx` keep their values.
- R10: In a partial load the sign flag has no effect on `wrData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word and operands are valid this cycle |
| instWord | input | 32 | Instruction word |
| modeSel | input | 2 | 00 pass, 01 constant load, 10 zero extend, 11 pass |
| loadOpcode | input | 8 | Opcode value recognised as a constant load |
| regOld | input | 64 | Current contents of the destination register |
| xbarResult | input | 64 | Normal result from the execution crossbar |
| wrData | output | 64 | Registered write data |
| wrIdx | output | 6 | Registered destination register index |
| wrEn | output | 1 | Registered write enable, one cycle per valid instruction |

## Verification
Immediates with the top bit clear and with the top bit set are loaded under both values of the sign flag. This separates sign fill from zero fill, and it also shows that a partial load ignores the flag. The old-register and crossbar operands use distinct byte patterns, including an all-ones old value, so that the stimulus shows whether the shift moved the correct 48 bits and whether the wrong source was selected. Words that carry a constant-load opcode are also sent in the pass-through, reserved and zero-extend modes, and a mismatched opcode is sent in the constant-load mode; in each case only the crossbar value may appear. Idle and back-to-back cycles separate the one-cycle write enable from stale held data.

// File: rtl/cload_pkg.sv
package cload_pkg;
  localparam int DATA_W = 64;
  localparam int IMM_W  = 16;
  localparam int IDX_W  = 6;
  localparam int OPC_W  = 8;
  localparam int INST_W = OPC_W + 2 + IMM_W + IDX_W;

  // Field positions within the instruction word
  localparam int IDX_LSB = 0;
  localparam int IMM_LSB = IDX_LSB + IDX_W;
  localparam int SGN_BIT = IMM_LSB + IMM_W;
  localparam int PRT_BIT = SGN_BIT + 1;
  localparam int OPC_LSB = PRT_BIT + 1;

  // modeSel encodings
  localparam logic [1:0] MODE_PASS  = 2'b00;
  localparam logic [1:0] MODE_CONST = 2'b01;
  localparam logic [1:0] MODE_ZEXT  = 2'b10;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_FULL = 2'd1,
    SEL_PART = 2'd2,
    SEL_ZEXT = 2'd3
  } muxSelT;

  typedef struct packed {
    muxSelT            muxSel;
    logic              signFill;
    logic              capture;
    logic [IMM_W-1:0]  imm;
    logic [IDX_W-1:0]  dstIdx;
  } ctrlStrobesT;
endpackage

// File: rtl/cload_ctrl.sv
module cload_ctrl
  import cload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [1:0]        modeSel,
  input  logic [OPC_W-1:0]  loadOpcode,
  output ctrlStrobesT       strobes
);
  logic [OPC_W-1:0] opcField;
  logic             partFlag;
  logic             opcHit;

  assign opcField = instWord[OPC_LSB +: OPC_W];
  assign partFlag = instWord[PRT_BIT];
  assign opcHit   = (opcField == loadOpcode);

  always_comb begin
    strobes.muxSel   = SEL_PASS;
    strobes.signFill = instWord[SGN_BIT];
    strobes.capture  = instValid;
    strobes.imm      = instWord[IMM_LSB +: IMM_W];
    strobes.dstIdx   = instWord[IDX_LSB +: IDX_W];
    unique case (modeSel)
      MODE_CONST: begin
        if (opcHit) strobes.muxSel = partFlag ? SEL_PART : SEL_FULL;
      end
      MODE_ZEXT: strobes.muxSel = SEL_ZEXT;
      default:   strobes.muxSel = SEL_PASS;
    endcase
  end

  // R8: a wrong opcode never reaches a constant source
  a_r8_mismatch_pass: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_CONST && !opcHit) |-> (strobes.muxSel == SEL_PASS));
  // R6: pass and reserved modes never select a constant source
  a_r6_pass_modes: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_PASS || modeSel == 2'b11) |-> (strobes.muxSel == SEL_PASS));
endmodule

// File: rtl/cload_dpath.sv
module cload_dpath
  import cload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] regOld,
  input  logic [DATA_W-1:0] xbarResult,
  output logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrEn
);
  localparam int HI_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] fullVal, partVal, zextVal, nextData;

  assign fullVal = {{HI_W{strobes.signFill}}, strobes.imm};
  assign partVal = {regOld[HI_W-1:0], strobes.imm};
  assign zextVal = {{HI_W{1'b0}}, xbarResult[IMM_W-1:0]};

  always_comb begin
    unique case (strobes.muxSel)
      SEL_FULL: nextData = fullVal;
      SEL_PART: nextData = partVal;
      SEL_ZEXT: nextData = zextVal;
      default:  nextData = xbarResult;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrData <= '0;
      wrIdx  <= '0;
      wrEn   <= 1'b0;
    end else begin
      wrEn <= strobes.capture;
      if (strobes.capture) begin
        wrData <= nextData;
        wrIdx  <= strobes.dstIdx;
      end
    end
  end

  // R9: one enable per accepted word, none otherwise, data held when idle
  a_r9_enable_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> wrEn);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> (!wrEn && $stable(wrData) && $stable(wrIdx)));
  // R5: partial load carries the old low bits up by one immediate width
  a_r5_partial_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.muxSel == SEL_PART)
      |=> (wrData[DATA_W-1:IMM_W] == $past(regOld[HI_W-1:0])));
  // R7: zero extend clears all upper bits
  a_r7_zext_upper: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.muxSel == SEL_ZEXT)
      |=> (wrData[DATA_W-1:IMM_W] == '0));
endmodule

// File: rtl/cload_wsel.sv
module cload_wsel
  import cload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [1:0]        modeSel,
  input  logic [OPC_W-1:0]  loadOpcode,
  input  logic [DATA_W-1:0] regOld,
  input  logic [DATA_W-1:0] xbarResult,
  output logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrEn
);
  ctrlStrobesT strobes;

  cload_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .modeSel(modeSel), .loadOpcode(loadOpcode), .strobes(strobes)
  );

  cload_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regOld(regOld),
    .xbarResult(xbarResult), .wrData(wrData), .wrIdx(wrIdx), .wrEn(wrEn)
  );

  // R2: destination index comes from the low field of the accepted word
  a_r2_index_field: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> (wrIdx == $past(instWord[IDX_LSB +: IDX_W])));
  // R1: reset leaves the write port quiet and cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!wrEn && wrData == '0 && wrIdx == '0));
endmodule

// File: tb/cload_wsel_test.sv
module cload_wsel_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [31:0] instWord;
  logic [1:0]  modeSel;
  logic [7:0]  loadOpcode;
  logic [63:0] regOld, xbarResult;
  logic [63:0] wrData;
  logic [5:0]  wrIdx;
  logic        wrEn;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;  // 125 MHz

  cload_wsel uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .modeSel(modeSel), .loadOpcode(loadOpcode), .regOld(regOld),
    .xbarResult(xbarResult), .wrData(wrData), .wrIdx(wrIdx), .wrEn(wrEn)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] inst;
    logic [63:0] old;
    logic [63:0] xbar;
    logic [63:0] expData;
    logic [7:0]  req;
  } vecT;

  localparam logic [63:0] OLDA = 64'h1122_3344_5566_7788;
  localparam logic [63:0] XB   = 64'hDEAD_BEEF_CAFE_F00D;

  // inst = {opcode, partial, sign, imm16, idx6}; loadOpcode is 8'hA5
  localparam vecT VECS [10] = '{
    '{2'b01, {8'hA5,1'b0,1'b0,16'h7777,6'd5},  OLDA, XB, 64'h0000_0000_0000_7777, 8'd3},  // R3
    '{2'b01, {8'hA5,1'b0,1'b1,16'h8001,6'd63}, OLDA, XB, 64'hFFFF_FFFF_FFFF_8001, 8'd4},  // R4
    '{2'b01, {8'hA5,1'b0,1'b0,16'h8001,6'd2},  OLDA, XB, 64'h0000_0000_0000_8001, 8'd3},  // R3
    '{2'b01, {8'hA5,1'b1,1'b0,16'h33BB,6'd42}, OLDA, XB, 64'h3344_5566_7788_33BB, 8'd5},  // R5
    '{2'b01, {8'hA5,1'b1,1'b1,16'h33BB,6'd1},  OLDA, XB, 64'h3344_5566_7788_33BB, 8'd10}, // R10
    '{2'b01, {8'hA5,1'b1,1'b0,16'h0000,6'd7},  64'hFFFF_FFFF_FFFF_FFFF, XB, 64'hFFFF_FFFF_FFFF_0000, 8'd5}, // R5
    '{2'b00, {8'hA5,1'b0,1'b1,16'h1234,6'd9},  OLDA, XB, XB, 8'd6},                    // R6
    '{2'b11, {8'hA5,1'b1,1'b0,16'h1234,6'd11}, OLDA, XB, XB, 8'd6},                    // R6
    '{2'b10, {8'hA5,1'b0,1'b1,16'h1234,6'd17}, OLDA, XB, 64'h0000_0000_0000_F00D, 8'd7}, // R7
    '{2'b01, {8'h5A,1'b0,1'b0,16'h7777,6'd3},  OLDA, XB, XB, 8'd8}                     // R8
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [31:0] w, input logic [63:0] o, input logic [63:0] x);
    modeSel = m; instWord = w; regOld = o; xbarResult = x; instValid = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; instValid = 1'b0; instWord = '0; modeSel = 2'b00;
    loadOpcode = 8'hA5; regOld = '0; xbarResult = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wrEn == 1'b0, "R1 wrEn", {63'd0, wrEn}, 64'd0);
    chk(wrData == '0, "R1 wrData", wrData, 64'd0);
    chk(wrIdx == '0, "R1 wrIdx", {58'd0, wrIdx}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      drive(VECS[i].mode, VECS[i].inst, VECS[i].old, VECS[i].xbar);
      @(negedge clk);
      instValid = 1'b0;
      chk(wrData == VECS[i].expData, $sformatf("R%0d data vec%0d", VECS[i].req, i), wrData, VECS[i].expData);
      chk(wrIdx == VECS[i].inst[5:0], $sformatf("R2 idx vec%0d", i), {58'd0, wrIdx}, {58'd0, VECS[i].inst[5:0]});
      chk(wrEn == 1'b1, $sformatf("R9 enable vec%0d", i), {63'd0, wrEn}, 64'd1);
    end

    // R9: idle cycle drops enable and holds data/index even as inputs change
    drive(2'b00, {8'hA5,1'b0,1'b0,16'hAAAA,6'd20}, OLDA, 64'h0123_4567_89AB_CDEF);
    instValid = 1'b0;
    @(negedge clk);
    chk(wrEn == 1'b0, "R9 idle enable", {63'd0, wrEn}, 64'd0);
    chk(wrData == XB, "R9 idle hold data", wrData, XB);
    chk(wrIdx == 6'd3, "R9 idle hold idx", {58'd0, wrIdx}, 64'd3);

    // R9: back-to-back words give two consecutive enables with their own data
    drive(2'b01, {8'hA5,1'b0,1'b1,16'h0042,6'd12}, OLDA, XB);
    @(negedge clk);
    chk(wrEn == 1'b1, "R9 b2b first enable", {63'd0, wrEn}, 64'd1);
    chk(wrData == 64'hFFFF_FFFF_FFFF_0042, "R4 b2b first data", wrData, 64'hFFFF_FFFF_FFFF_0042);
    drive(2'b10, {8'h00,1'b1,1'b1,16'hFFFF,6'd13}, OLDA, 64'h8765_4321_0000_ABCD);
    @(negedge clk);
    instValid = 1'b0;
    chk(wrEn == 1'b1, "R9 b2b second enable", {63'd0, wrEn}, 64'd1);
    chk(wrData == 64'h0000_0000_0000_ABCD, "R7 b2b second data", wrData, 64'h0000_0000_0000_ABCD);
    chk(wrIdx == 6'd13, "R2 b2b second idx", {58'd0, wrIdx}, 64'd13);
    @(negedge clk);
    chk(wrEn == 1'b0, "R9 single-cycle enable", {63'd0, wrEn}, 64'd0);

    // R8: changing the programmed opcode makes the old opcode pass through
    loadOpcode = 8'h3C;
    drive(2'b01, {8'hA5,1'b0,1'b0,16'h7777,6'd4}, OLDA, XB);
    @(negedge clk);
    instValid = 1'b0;
    chk(wrData == XB, "R8 reprogrammed mismatch", wrData, XB);
    drive(2'b01, {8'h3C,1'b1,1'b0,16'h5555,6'd4}, OLDA, XB);
    @(negedge clk);
    instValid = 1'b0;
    chk(wrData == 64'h3344_5566_7788_5555, "R5 reprogrammed match", wrData, 64'h3344_5566_7788_5555);

    // R1: reset mid-run clears outputs even with a valid word present
    drive(2'b01, {8'h3C,1'b0,1'b1,16'h1111,6'd30}, OLDA, XB);
    rstN = 1'b0;
    @(negedge clk);
    chk(wrEn == 1'b0, "R1 midrun enable", {63'd0, wrEn}, 64'd0);
    chk(wrData == '0, "R1 midrun data", wrData, 64'd0);
    chk(wrIdx == '0, "R1 midrun idx", {58'd0, wrIdx}, 64'd0);
    instValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    doneFlag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule